// File: doc/BRIEF.md
# Write-Once Nonvolatile-Memory Clock Divider

This block holds the 8-bit setting that divides the bus clock down to the timebase needed by a nonvolatile-memory program/erase state machine, and it produces that timebase as a one-cycle clock-enable pulse. Software writes the divide value and an optional divide-by-8 prescale. Only the first write after reset is taken. Every later write is dropped. A read-only flag in the top bit of the readback shows that the setting has been loaded.

The loaded flag also acts as the permission for program and erase work. Until the flag is set, the block produces no clock-enable pulses. Any command request made in that state is refused with a one-cycle access-error pulse. The erase and program controllers that use the enable pulse and the permit are outside this block.

Bus writes are plain strobes. There is no handshake and no back-pressure: a write strobe is taken on the clock edge where it is high, and readback is a continuous view of the register. The command request is also a plain level and is sampled on every edge.

Top module: `nvm_clkdiv_reg`

## Requirements
- R1: While reset is asserted, and after it is released, rd_data reads 0x00 and pe_permit, tick and acc_err are 0.
- R2: The first write after reset captures wr_data[6] as the prescale bit and wr_data[5:0] as the divide value. They read back at rd_data[6] and rd_data[5:0] from the next cycle on.
- R3: Every write after the first one leaves rd_data[6:0] unchanged until the next reset.
- R4: The first write sets the loaded flag, read at rd_data[7], whatever value wr_data[7] carries. The flag stays 1 until reset, and later writes cannot clear it.
- R5: pe_permit equals the loaded flag on every cycle.
- R6: A command request (cmd_req high on a clock edge) made while the flag is still 0 at that edge gives acc_err = 1 for exactly the following cycle. This includes a request on the same edge as the first write. A request made while the flag is 1 gives no acc_err.
- R7: tick stays 0 for as long as the loaded flag is 0.
- R8: With the prescale bit at 0 and divide value D, tick is 1 on cycle D after loading (the cycle right after the load edge is cycle 0), and then once every D+1 cycles.
- R9: With the prescale bit at 1 and divide value D, tick is 1 on cycle 8*D+7 after loading, and then once every 8*(D+1) cycles.
- R10: With the prescale bit at 0 and D = 0, tick is 1 on every cycle after loading.
- R11: A reset asserted during operation returns the block to the state in R1, and the next write is again taken as the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 6 is the prescale bit, bits 5:0 are the divide value, bit 7 is ignored |
| rd_data | output | 8 | Readback: bit 7 is the loaded flag, bit 6 is the prescale bit, bits 5:0 are the divide value |
| cmd_req | input | 1 | Program/erase command attempt |
| pe_permit | output | 1 | Program/erase permitted (loaded flag) |
| acc_err | output | 1 | One-cycle pulse for a refused command |
| tick | output | 1 | Divided clock-enable pulse |

## Verification
The hardest cases to reach from the ports need a reset, because the write-once latch can only be reopened by one. The stimulus resets the block in the middle of operation several times. After each reset it loads a new setting: a divide value of 0, a normal divide value, and the prescaled path. One of those loads is issued on the same edge as a command request, so the ordering between the error check and the load is tested. The prescaled setting is left running for several full periods of 8*(D+1) cycles. Over that run, a reference model that counts cycles since loading checks the first tick position and the spacing between ticks.

// File: rtl/nvm_clkdiv_pkg.sv
package nvm_clkdiv_pkg;
  localparam int DIV_W   = 6;
  localparam int REG_W   = DIV_W + 2;
  localparam int PRE_FAC = 8;

  typedef struct packed {
    logic             pre;
    logic [DIV_W-1:0] div;
  } div_cfg_t;
endpackage

// File: rtl/nvm_cdr_cfg.sv
module nvm_cdr_cfg
  import nvm_clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output div_cfg_t         cfg,
  output logic             loaded
);
  logic ign_unused_top;
  assign ign_unused_top = wr_data[REG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      loaded <= 1'b0;
    end else if (wr_en && !loaded) begin
      cfg    <= div_cfg_t'(wr_data[REG_W-2:0]);
      loaded <= 1'b1;
    end
  end

  p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loaded) |-> $stable(cfg));
  p_loaded_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
endmodule

// File: rtl/nvm_cdr_prescale.sv
module nvm_cdr_prescale #(
  parameter int FACTOR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  output logic stage_en
);
  generate
    if (FACTOR > 1) begin : g_div
      localparam int PW = $clog2(FACTOR);
      localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);
      logic [PW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!run || bypass)  cnt <= '0;
        else if (cnt == LAST)     cnt <= '0;
        else                      cnt <= cnt + 1'b1;
      end

      assign stage_en = run && (bypass || (cnt == LAST));

      p_pre_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass && stage_en) |=> !stage_en);
    end else begin : g_pass
      logic ign_unused_byp;
      assign ign_unused_byp = bypass;
      assign stage_en = run;
      logic ign_unused_clk;
      assign ign_unused_clk = clk ^ rst_n;
    end
  endgenerate
endmodule

// File: rtl/nvm_cdr_divcnt.sv
module nvm_cdr_divcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (step) begin
      if (cnt == limit)    cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assign tick = step && (cnt == limit);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/nvm_cdr_gate.sv
module nvm_cdr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_req,
  input  logic loaded,
  output logic pe_permit,
  output logic acc_err
);
  assign pe_permit = loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= cmd_req && !loaded;
  end

  p_err_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(cmd_req));
endmodule

// File: rtl/nvm_clkdiv_reg.sv
module nvm_clkdiv_reg
  import nvm_clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             cmd_req,
  output logic             pe_permit,
  output logic             acc_err,
  output logic             tick
);
  div_cfg_t cfg;
  logic     loaded;
  logic     stage_en;

  nvm_cdr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .loaded(loaded)
  );

  nvm_cdr_prescale #(.FACTOR(PRE_FAC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(loaded), .bypass(!cfg.pre),
    .stage_en(stage_en)
  );

  nvm_cdr_divcnt #(.W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(loaded), .step(stage_en),
    .limit(cfg.div), .tick(tick)
  );

  nvm_cdr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .loaded(loaded),
    .pe_permit(pe_permit), .acc_err(acc_err)
  );

  assign rd_data = {loaded, cfg};

  p_permit_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pe_permit == rd_data[REG_W-1]);
  p_no_tick_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_permit |-> !tick);
  p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[REG_W-2:0] != '0) |=> !tick);
endmodule

// File: tb/sim_nvm_clkdiv_reg.sv
`timescale 1ns/1ps
module sim_nvm_clkdiv_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_req = 1'b0;
  logic [7:0] rd_data;
  logic       pe_permit, acc_err, tick;

  always #2.5 clk = ~clk;

  nvm_clkdiv_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_req(cmd_req), .pe_permit(pe_permit),
    .acc_err(acc_err), .tick(tick)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string req = "R1";

  // behavioural reference
  bit     m_loaded, m_pre, m_err;
  int     m_div, m_k;

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int period;
    bit e_tick;
    cyc++;
    if (!rst_n) begin
      m_loaded = 0; m_pre = 0; m_div = 0; m_k = 0; m_err = 0;
    end else begin
      m_err = cmd_req && !m_loaded;
      if (m_loaded) m_k++;
      if (wr_en && !m_loaded) begin
        m_loaded = 1; m_pre = wr_data[6]; m_div = wr_data[5:0]; m_k = 0;
      end
    end
    period = (m_div + 1) * (m_pre ? 8 : 1);
    e_tick = m_loaded && (((m_k + 1) % period) == 0);
    #1;
    check("rd_data", rd_data, {m_loaded, m_pre, 6'(m_div)});
    check("pe_permit", pe_permit, m_loaded);
    check("acc_err", acc_err, m_err);
    check("tick", tick, e_tick);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk) begin wr_en = 0; cmd_req = 0; end
  endtask

  task automatic write(logic [7:0] v, bit with_cmd);
    @(negedge clk); wr_en = 1; wr_data = v; cmd_req = with_cmd;
    @(negedge clk); wr_en = 0; cmd_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    idle(3);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    idle(4);
    @(negedge clk); rst_n = 1;
    idle(3);
    // R6 / R7: commands refused before load, no ticks
    req = "R6";
    @(negedge clk); cmd_req = 1;
    @(negedge clk); cmd_req = 1;
    @(negedge clk); cmd_req = 0;
    req = "R7";
    idle(20);
    // R2 / R4: first write with bit 7 = 1, D=3, no prescale
    req = "R4";
    write(8'h83, 0);
    req = "R8";
    idle(24);
    // R3: later writes dropped
    req = "R3";
    write(8'h45, 0);
    write(8'h00, 0);
    idle(12);
    // R5 / R6: command accepted while loaded
    req = "R5";
    @(negedge clk); cmd_req = 1;
    @(negedge clk); cmd_req = 0;
    idle(4);
    // R11 + R10: reset mid-run, then D=0 with bit 7 = 0 (R2)
    req = "R11";
    do_reset();
    idle(3);
    req = "R10";
    write(8'h00, 0);
    idle(10);
    // R9: reset, load prescaled D=2 on same edge as a command (R6)
    req = "R6";
    do_reset();
    write(8'h42, 1);
    req = "R9";
    idle(100);
    // R9: prescaled D=0
    do_reset();
    write(8'h40, 0);
    idle(40);
    // R2: larger divide value
    req = "R2";
    do_reset();
    write(8'h3f, 0);
    idle(140);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule